// File: doc/BRIEF.md
# Multi-Channel DMA Command Frontend

This block is the control half of a cluster DMA engine that copies words from a level-2 memory into an L1 scratchpad. Each core owns a private configuration port, so programming never contends between cores. A core writes a source word address, a destination word address and a word count. Writing the count starts the command. After a fixed setup delay, the channel becomes eligible to issue.

Eligible channels take turns on a single memory request port, one word per turn. Every accepted request occupies one entry of a bounded table of outstanding transactions. The entry's index serves as the request tag. The entry records the owning channel and the destination address. When a response returns with that tag, the data goes out in the same cycle on the owning channel's dedicated scratchpad write port, and the entry is freed. The engine stores no data.

A per-channel done flag reports that every word of the last command has been written.

Top module: `dma_cmd_front`

## Requirements
- R1: Each channel has its own write strobe, select and data. The select codes are 0 for source address, 1 for destination address and 2 for word count, which also starts the command. Channels may be programmed in the same cycle without affecting one another.
- R2: With the table not full, the first request of a nonzero command is presented in the cycle after the SETUP_CYC-th clock edge that follows the edge capturing the count write. It is not presented before that cycle.
- R3: A command of N words issues exactly N requests, with addresses source+0 through source+N-1 in ascending order.
- R4: No more than MAX_OUT requests are outstanding. While the table is full, req_valid stays low. A new request never carries a tag that is still outstanding.
- R5: When every channel has words left to issue and req_ready is held high, consecutive accepted requests come from channels in rotating order. Each request comes from the channel one above the previous one, wrapping after the last channel.
- R6: Done rises on the clock edge that follows the edge at which the final response of the command is retired, and never earlier.
- R7: A count write with a nonzero value to an idle channel clears its done flag at the capturing edge.
- R8: A count write of zero to an idle channel sets done at the capturing edge and issues no request.
- R9: Configuration writes to a channel whose command is in progress are ignored.
- R10: After reset, done, req_valid and all scratchpad write strobes are low.
- R11: A response whose tag is outstanding drives, in the same cycle, exactly one scratchpad write strobe. That strobe belongs to the channel that issued the tag. The port carries destination+k as the address and the returned word as the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | NCH | Per-channel configuration write strobe |
| cfg_sel | input | 2*NCH | Per-channel register select, 2 bits each |
| cfg_wdata | input | AW*NCH | Per-channel write data, AW bits each |
| done | output | NCH | Per-channel completion flag |
| req_valid | output | 1 | Memory read request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_addr | output | AW | Level-2 word address of the request |
| req_tag | output | TW | Outstanding-table index carried by the request |
| rsp_valid | input | 1 | Response valid |
| rsp_tag | input | TW | Tag of the returning response |
| rsp_data | input | DW | Returned data word |
| spm_we | output | NCH | Per-channel scratchpad write strobe |
| spm_addr | output | AW*NCH | Per-channel scratchpad word address |
| spm_wdata | output | DW*NCH | Per-channel scratchpad write data |

## Verification
The due cycle differs for each result:
- A scratchpad write appears in the same cycle as its response, and a request is visible combinationally in the cycle it is presented. The bench therefore samples both a few nanoseconds after the edge that follows its input changes.
- The first request is due exactly SETUP_CYC edges after the count write is captured, and the bench counts those edges.
- Done is due one edge after the retiring edge. The bench checks that it is still low one cycle after the final response and high one cycle later.
- A zero count, or a nonzero count clearing done, takes effect at the capturing edge and is checked in the following cycle.

// File: rtl/dma_front_pkg.sv
package dma_front_pkg;

  // Register select codes on each channel's configuration port
  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_DST  = 2'd1,
    SEL_LEN  = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

endpackage

// File: rtl/dma_chan_ctx.sv
module dma_chan_ctx
  import dma_front_pkg::*;
#(
  parameter int AW        = 16,
  parameter int LW        = 8,
  parameter int OUTW      = 5,
  parameter int SETUP_CYC = 7,
  localparam int SW       = $clog2(SETUP_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          cfg_len_zero,
  input  logic          issue,
  input  logic          retire,
  output logic          eligible,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output logic          done
);

  logic [AW-1:0]   src_q, src_d, dst_q, dst_d;
  logic [LW-1:0]   rem_q, rem_d;
  logic [SW-1:0]   wait_q, wait_d;
  logic [OUTW-1:0] out_q, out_d;
  logic            active_q, active_d, done_q, done_d;

  always_comb begin
    src_d    = src_q;
    dst_d    = dst_q;
    rem_d    = rem_q;
    wait_d   = wait_q;
    out_d    = out_q;
    active_d = active_q;
    done_d   = done_q;
    if (!active_q) begin
      if (cfg_we) begin
        case (cfg_sel)
          SEL_SRC: src_d = cfg_wdata;
          SEL_DST: dst_d = cfg_wdata;
          SEL_LEN: begin
            if (cfg_len_zero) begin
              done_d = 1'b1;
            end else begin
              active_d = 1'b1;
              done_d   = 1'b0;
              rem_d    = cfg_wdata[LW-1:0];
              wait_d   = SW'(SETUP_CYC);
            end
          end
          default: ;
        endcase
      end
    end else begin
      if (wait_q != '0) wait_d = wait_q - SW'(1);
      if (issue) begin
        src_d = src_q + AW'(1);
        dst_d = dst_q + AW'(1);
        rem_d = rem_q - LW'(1);
      end
      out_d = out_q + OUTW'(issue) - OUTW'(retire);
      if (rem_q == '0 && out_q == '0) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end
    end
  end

  // Control state with reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      rem_q    <= '0;
      wait_q   <= '0;
      out_q    <= '0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      rem_q    <= rem_d;
      wait_q   <= wait_d;
      out_q    <= out_d;
    end
  end

  // Address registers: datapath, no reset
  always_ff @(posedge clk) begin
    src_q <= src_d;
    dst_q <= dst_d;
  end

  assign eligible = active_q && (wait_q == '0) && (rem_q != '0);
  assign src_addr = src_q;
  assign dst_addr = dst_q;
  assign done     = done_q;

endmodule

// File: rtl/dma_rr_arb.sv
module dma_rr_arb #(
  parameter int N  = 4,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic          any,
  output logic [CW-1:0] gnt_idx
);

  logic [CW-1:0] last_q, last_d;

  always_comb begin
    any     = 1'b0;
    gnt_idx = last_q;
    for (int k = 1; k <= N; k++) begin
      if (!any && req[(int'(last_q) + k) % N]) begin
        any     = 1'b1;
        gnt_idx = CW'((int'(last_q) + k) % N);
      end
    end
    last_d = advance ? gnt_idx : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= CW'(N - 1);
    else        last_q <= last_d;
  end

endmodule

// File: rtl/dma_txn_table.sv
module dma_txn_table #(
  parameter int AW    = 16,
  parameter int DEPTH = 16,
  parameter int TW    = 4,
  parameter int CHW   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc,
  input  logic [CHW-1:0] alloc_ch,
  input  logic [AW-1:0]  alloc_dst,
  input  logic           rsp_valid,
  input  logic [TW-1:0]  rsp_tag,
  output logic           full,
  output logic [TW-1:0]  free_tag,
  output logic           hit,
  output logic [CHW-1:0] hit_ch,
  output logic [AW-1:0]  hit_dst
);

  logic [DEPTH-1:0] vld_q, vld_d;
  logic [CHW-1:0]   ch_q  [DEPTH];
  logic [AW-1:0]    dst_q [DEPTH];

  always_comb begin
    free_tag = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_tag = TW'(i);
    end
    full    = &vld_q;
    hit     = rsp_valid && vld_q[rsp_tag];
    hit_ch  = ch_q[rsp_tag];
    hit_dst = dst_q[rsp_tag];
    vld_d   = vld_q;
    if (hit)   vld_d[rsp_tag]  = 1'b0;
    if (alloc) vld_d[free_tag] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (alloc && free_tag == TW'(g)) begin
        ch_q[g]  <= alloc_ch;
        dst_q[g] <= alloc_dst;
      end
    end
  end

endmodule

// File: rtl/dma_cmd_front.sv
module dma_cmd_front
  import dma_front_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int LW        = 8,
  parameter int MAX_OUT   = 16,
  parameter int SETUP_CYC = 7,
  localparam int CHW      = $clog2(NCH),
  localparam int TW       = $clog2(MAX_OUT),
  localparam int OUTW     = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cfg_we,
  input  logic [2*NCH-1:0]  cfg_sel,
  input  logic [AW*NCH-1:0] cfg_wdata,
  output logic [NCH-1:0]    done,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  output logic [TW-1:0]     req_tag,
  input  logic              rsp_valid,
  input  logic [TW-1:0]     rsp_tag,
  input  logic [DW-1:0]     rsp_data,
  output logic [NCH-1:0]    spm_we,
  output logic [AW*NCH-1:0] spm_addr,
  output logic [DW*NCH-1:0] spm_wdata
);

  logic [NCH-1:0] elig, len_zero;
  logic [AW-1:0]  src_a [NCH];
  logic [AW-1:0]  dst_a [NCH];
  logic           any_req, full, hs, hit;
  logic [CHW-1:0] gnt_idx, hit_ch;
  logic [TW-1:0]  free_tag;
  logic [AW-1:0]  hit_dst;

  assign req_valid = any_req && !full;
  assign hs        = req_valid && req_ready;
  assign req_addr  = src_a[gnt_idx];
  assign req_tag   = free_tag;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign len_zero[g] = (cfg_wdata[g*AW +: LW] == '0);

    dma_chan_ctx #(
      .AW(AW), .LW(LW), .OUTW(OUTW), .SETUP_CYC(SETUP_CYC)
    ) u_ctx (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_we       (cfg_we[g]),
      .cfg_sel      (cfg_sel[2*g +: 2]),
      .cfg_wdata    (cfg_wdata[g*AW +: AW]),
      .cfg_len_zero (len_zero[g]),
      .issue        (hs && gnt_idx == CHW'(g)),
      .retire       (hit && hit_ch == CHW'(g)),
      .eligible     (elig[g]),
      .src_addr     (src_a[g]),
      .dst_addr     (dst_a[g]),
      .done         (done[g])
    );

    assign spm_we[g]              = hit && hit_ch == CHW'(g);
    assign spm_addr[g*AW +: AW]   = hit_dst;
    assign spm_wdata[g*DW +: DW]  = rsp_data;
  end

  dma_rr_arb #(.N(NCH), .CW(CHW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (elig),
    .advance (hs),
    .any     (any_req),
    .gnt_idx (gnt_idx)
  );

  dma_txn_table #(.AW(AW), .DEPTH(MAX_OUT), .TW(TW), .CHW(CHW)) u_tbl (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc     (hs),
    .alloc_ch  (gnt_idx),
    .alloc_dst (dst_a[gnt_idx]),
    .rsp_valid (rsp_valid),
    .rsp_tag   (rsp_tag),
    .full      (full),
    .free_tag  (free_tag),
    .hit       (hit),
    .hit_ch    (hit_ch),
    .hit_dst   (hit_dst)
  );

endmodule

// File: rtl/dma_cmd_front_chk.sv
module dma_cmd_front_chk #(
  parameter int NCH     = 4,
  parameter int MAX_OUT = 16,
  localparam int CHW    = $clog2(NCH),
  localparam int TW     = $clog2(MAX_OUT),
  localparam int OUTW   = $clog2(MAX_OUT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCH-1:0]   cfg_we,
  input logic [2*NCH-1:0] cfg_sel,
  input logic [NCH-1:0]   len_zero,
  input logic [NCH-1:0]   done,
  input logic             req_valid,
  input logic             req_ready,
  input logic [TW-1:0]    req_tag,
  input logic             rsp_valid,
  input logic [TW-1:0]    rsp_tag,
  input logic [NCH-1:0]   spm_we,
  input logic [CHW-1:0]   gnt_idx
);

  logic [MAX_OUT-1:0] tag_busy;
  logic [OUTW:0]      tot;
  logic [OUTW-1:0]    ch_out [NCH];
  logic [NCH-1:0]     ch_busy;
  logic               hs, rsp_ok;

  assign hs     = req_valid && req_ready;
  assign rsp_ok = rsp_valid && tag_busy[rsp_tag];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_busy <= '0;
      tot      <= '0;
    end else begin
      for (int t = 0; t < MAX_OUT; t++) begin
        if (rsp_ok && rsp_tag == TW'(t)) tag_busy[t] <= 1'b0;
        if (hs && req_tag == TW'(t))     tag_busy[t] <= 1'b1;
      end
      tot <= tot + (OUTW+1)'(hs) - (OUTW+1)'(rsp_ok);
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_out[i]  <= '0;
        ch_busy[i] <= 1'b0;
      end else begin
        ch_out[i] <= ch_out[i] + OUTW'(hs && gnt_idx == CHW'(i)) - OUTW'(spm_we[i]);
        if (cfg_we[i] && cfg_sel[2*i +: 2] == 2'd2 && !len_zero[i] && (!ch_busy[i] || done[i]))
          ch_busy[i] <= 1'b1;
        else if (done[i])
          ch_busy[i] <= 1'b0;
      end
    end

    // R6: completion only once the channel has nothing outstanding
    assert_done_drained_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done[i]) |-> ch_out[i] == '0)
      else $error("done rose with transactions outstanding");

    // R8: zero count to an idle channel completes at once
    assert_zero_len_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we[i] && cfg_sel[2*i +: 2] == 2'd2 && len_zero[i] && (!ch_busy[i] || done[i]))
      |=> done[i])
      else $error("zero-length command did not complete");
  end

  assert_outstanding_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tot <= (OUTW+1)'(MAX_OUT))
    else $error("outstanding limit exceeded");

  assert_tag_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hs |-> !tag_busy[req_tag])
    else $error("tag reused while outstanding");

  assert_rsp_single_port_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> $countones(spm_we) == 1)
    else $error("response not routed to exactly one port");

endmodule

bind dma_cmd_front dma_cmd_front_chk #(.NCH(NCH), .MAX_OUT(MAX_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_sel   (cfg_sel),
  .len_zero  (len_zero),
  .done      (done),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_tag   (req_tag),
  .rsp_valid (rsp_valid),
  .rsp_tag   (rsp_tag),
  .spm_we    (spm_we),
  .gnt_idx   (gnt_idx)
);

// File: tb/dma_cmd_front_test.sv
`timescale 1ns/1ps
module dma_cmd_front_test;

  logic         clk, rst_n;
  logic [3:0]   cfg_we;
  logic [7:0]   cfg_sel;
  logic [63:0]  cfg_wdata;
  logic [3:0]   done;
  logic         req_valid, req_ready;
  logic [15:0]  req_addr;
  logic [3:0]   req_tag;
  logic         rsp_valid;
  logic [3:0]   rsp_tag;
  logic [31:0]  rsp_data;
  logic [3:0]   spm_we;
  logic [63:0]  spm_addr;
  logic [127:0] spm_wdata;

  dma_cmd_front uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .done(done), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_data(rsp_data),
    .spm_we(spm_we), .spm_addr(spm_addr), .spm_wdata(spm_wdata)
  );

  localparam int SETUP = 7;

  int m_src0 [4], m_dst0 [4], m_len [4], m_next [4], m_got [4];
  bit m_busy [4];
  int pend_tag [17], pend_addr [17];
  int npend, rel_req, rel_done, rr_last, rr_cnt;
  bit auto_rsp, ready_mode, rr_mode, mon_on;
  int checks, errors;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] fdat(input int a);
    return {16'(a) ^ 16'h5A3C, 16'(a)};
  endfunction

  function automatic bit any_busy();
    return m_busy[0] | m_busy[1] | m_busy[2] | m_busy[3];
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // R1: program the channels in mask in parallel through their own ports
  task automatic prog(input logic [3:0] mask, input int soff, input int dbase, input int len);
    for (int s = 0; s < 3; s++) begin
      @(posedge clk); #1;
      for (int i = 0; i < 4; i++) begin
        if (mask[i]) begin
          cfg_we[i]         = 1'b1;
          cfg_sel[2*i +: 2] = 2'(s);
          cfg_wdata[16*i +: 16] = (s == 0) ? 16'((i << 12) | soff)
                                : (s == 1) ? 16'(dbase + (i << 8)) : 16'(len);
        end
      end
    end
    @(posedge clk); #1;
    cfg_we = cfg_we & ~mask;
    for (int i = 0; i < 4; i++) begin
      if (mask[i]) begin
        m_src0[i] = (i << 12) | soff;
        m_dst0[i] = (dbase + (i << 8)) & 16'hFFFF;
        m_len[i]  = len;
        m_next[i] = m_src0[i];
        m_got[i]  = 0;
        m_busy[i] = 1'b1;
      end
    end
  endtask

  task automatic wr(input int ch, input int sel, input int val);
    @(posedge clk); #1;
    cfg_we[ch] = 1'b1;
    cfg_sel[2*ch +: 2] = 2'(sel);
    cfg_wdata[16*ch +: 16] = 16'(val);
    @(posedge clk); #1;
    cfg_we[ch] = 1'b0;
  endtask

  task automatic wait_idle(input int lim);
    int n = 0;
    while (n < lim && (any_busy() || npend != 0)) begin
      @(posedge clk); #4;
      n++;
    end
    chk(n < lim, "R3 completion", n, lim);
  endtask

  // Memory model, responder and output monitor
  initial begin
    rsp_valid = 1'b0; rsp_tag = '0; rsp_data = '0; req_ready = 1'b0;
    wait (mon_on);
    forever begin
      @(posedge clk); #1;
      rsp_valid = 1'b0;
      if (npend > 0 && (auto_rsp ? ($urandom % 3 == 0) : (rel_req > rel_done))) begin
        int idx;
        idx = auto_rsp ? int'($urandom % npend) : 0;
        rsp_tag  = 4'(pend_tag[idx]);
        rsp_data = fdat(pend_addr[idx]);
        rsp_valid = 1'b1;
        for (int j = idx; j < npend - 1; j++) begin
          pend_tag[j]  = pend_tag[j+1];
          pend_addr[j] = pend_addr[j+1];
        end
        npend--;
        if (!auto_rsp) rel_done++;
      end
      req_ready = ready_mode ? 1'b1 : ($urandom % 10 < 7);
      #2;
      if (rsp_valid) begin
        int a, ch, ed;
        a  = int'(rsp_data[15:0]);
        ch = a >> 12;
        ed = (m_dst0[ch] + (a - m_src0[ch])) & 16'hFFFF;
        chk(spm_we == 4'(1 << ch), "R11 strobe", spm_we, 1 << ch);
        chk(spm_addr[16*ch +: 16] == 16'(ed), "R11 address", spm_addr[16*ch +: 16], ed);
        chk(spm_wdata[32*ch +: 32] == fdat(a), "R11 data", spm_wdata[32*ch +: 32], fdat(a));
        m_got[ch]++;
      end else begin
        chk(spm_we == 4'b0, "R11 idle strobe", spm_we, 0);
      end
      if (req_valid && req_ready) begin
        int ch;
        ch = int'(req_addr) >> 12;
        chk(ch < 4 && m_busy[ch], "R3 owner", ch, 0);
        if (ch < 4) begin
          chk(int'(req_addr) == m_next[ch] && m_next[ch] < m_src0[ch] + m_len[ch],
              "R3 address", req_addr, m_next[ch]);
          m_next[ch]++;
          if (rr_mode) begin
            if (rr_cnt > 0) chk(ch == (rr_last + 1) % 4, "R5 rotation", ch, (rr_last + 1) % 4);
            rr_last = ch;
            rr_cnt++;
          end
        end
        for (int j = 0; j < npend; j++)
          chk(pend_tag[j] != int'(req_tag), "R4 tag unique", req_tag, pend_tag[j]);
        chk(npend < 16, "R4 limit", npend + 1, 16);
        pend_tag[npend]  = int'(req_tag);
        pend_addr[npend] = int'(req_addr);
        npend++;
      end
      for (int i = 0; i < 4; i++) begin
        if (m_busy[i] && done[i]) begin
          chk(m_got[i] == m_len[i], "R6 words written", m_got[i], m_len[i]);
          chk(m_next[i] == m_src0[i] + m_len[i], "R3 word count", m_next[i], m_src0[i] + m_len[i]);
          m_busy[i] = 1'b0;
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int first;
    void'($urandom(32'd20240611));
    checks = 0; errors = 0; npend = 0; rel_req = 0; rel_done = 0;
    auto_rsp = 1'b1; ready_mode = 1'b0; rr_mode = 1'b0; rr_cnt = 0; rr_last = 0; mon_on = 1'b0;
    for (int i = 0; i < 4; i++) m_busy[i] = 1'b0;
    cfg_we = '0; cfg_sel = '0; cfg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #3;
    chk(done == 4'b0, "R10 done", done, 0);
    chk(req_valid == 1'b0, "R10 req_valid", req_valid, 0);
    chk(spm_we == 4'b0, "R10 strobes", spm_we, 0);
    mon_on = 1'b1;

    // R2: setup latency from the count capture to the first request
    prog(4'b0001, 'h010, 'h100, 3);
    first = -1;
    for (int k = 0; k < 10; k++) begin
      #3;
      if (req_valid && first < 0) first = k;
      @(posedge clk); #1;
    end
    chk(first == SETUP, "R2 first request", first, SETUP);
    wait_idle(400);

    // R8 zero count, then R7 clear on a new command
    prog(4'b1000, 'h000, 'h000, 0);
    #3;
    chk(done[3] == 1'b1, "R8 done at once", done[3], 1);
    chk(req_valid == 1'b0, "R8 no request", req_valid, 0);
    prog(4'b1000, 'h030, 'h600, 2);
    #3;
    chk(done[3] == 1'b0, "R7 done cleared", done[3], 0);
    wait_idle(400);
    chk(done[3] == 1'b1, "R7 done after transfer", done[3], 1);

    // R9: writes during an active command are ignored
    prog(4'b0001, 'h100, 'h040, 6);
    wr(0, 0, 'h0300);
    wr(0, 2, 0);
    #3;
    chk(done[0] == 1'b0, "R9 count write ignored", done[0], 0);
    wait_idle(400);

    // R6: done timing relative to the final retirement
    auto_rsp = 1'b0; ready_mode = 1'b1;
    prog(4'b0010, 'h010, 'h080, 1);
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #4;
      if (npend == 1) break;
    end
    chk(done[1] == 1'b0, "R6 before response", done[1], 0);
    rel_req++;
    @(posedge clk); @(posedge clk); #4;
    chk(done[1] == 1'b0, "R6 retiring edge", done[1], 0);
    @(posedge clk); #4;
    chk(done[1] == 1'b1, "R6 next edge", done[1], 1);
    wait_idle(100);

    // R4: table limit with no responses returning
    prog(4'b0101, 'h020, 'h400, 12);
    repeat (40) @(posedge clk);
    #4;
    chk(npend == 16, "R4 table full", npend, 16);
    chk(req_valid == 1'b0, "R4 stall when full", req_valid, 0);
    rel_req += 8;
    repeat (14) @(posedge clk);
    #4;
    chk(npend == 16, "R4 refill", npend, 16);
    rel_req += 16;
    wait_idle(400);
    auto_rsp = 1'b1;

    // R5 with R1: all channels programmed together, rotation order
    rr_mode = 1'b1; rr_cnt = 0;
    prog(4'b1111, 'h200, 'h800, 4);
    wait_idle(400);
    rr_mode = 1'b0;
    chk(rr_cnt == 16, "R5 request count", rr_cnt, 16);
    ready_mode = 1'b0;

    // Random traffic on all channels
    for (int r = 0; r < 40; r++) begin
      for (int i = 0; i < 4; i++) begin
        if (!m_busy[i] && ($urandom % 2 == 1))
          prog(4'(1 << i), int'($urandom % 'h800), int'($urandom % 'h10000), int'($urandom % 17));
      end
      repeat ($urandom % 20) @(posedge clk);
    end
    wait_idle(3000);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule